// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block models the column-burst side of a synchronous DRAM device. A READ or WRITE command on a small command bus, with a bank and a start column, starts a burst of 1, 2, 4 or 8 columns. The column order is sequential and wraps inside the aligned block whose size is the burst length. For writes, the block strobes out one captured data word per column with its bank and column, for the storage array to store. For reads, it presents an address to the storage array, registers the returned word and marks it valid.

A clock-enable input controls clock suspend. The block registers the enable on every rising edge, so its internal enable follows the input one edge late. While a burst is running, an edge whose internal enable is low is suspended. On a suspended edge the burst does not advance, the read output holds its word and valid flag, and any command or write data on the inputs is dropped. An output flag shows before each edge whether that edge will be suspended. When no burst is running, a low enable has no effect and commands are decoded as usual.

Top module: `sdram_burst_susp`

## Requirements
- R1: Synchronous active-high reset leaves no burst running, the read-valid flag low, the read data zero, the write strobe low and the internal enable high, so the first edge after reset is not suspended.
- R2: If the clock enable is low at a rising edge while a burst is running, the next rising edge is suspended. The `frozen` output is high before that edge.
- R3: On a suspended edge, `rdata` and `rvalid` keep the values they had.
- R4: On a suspended edge, `cmd` and `wdata` are ignored, `wstrobe` goes low and the burst column does not advance (`arr_col` is unchanged).
- R5: After the clock enable is registered high, the next edge is not suspended and the burst continues from the column where it stopped.
- R6: `cmd` codes are: 0 = no-op, 1 = READ, 2 = WRITE, 3 = no-op. A READ is accepted on a non-suspended edge. On each of the next BL non-suspended edges, `rdata` takes the array word for the next burst column (the start column first) and `rvalid` is high. On the following non-suspended edge, `rvalid` goes low.
- R7: A WRITE captures the start column with its `wdata` on the edge that carries the command. It then captures the next column on each of the next BL-1 non-suspended edges. After each capture edge `wstrobe` is high for one cycle, with `wbank`, `wcol` and `wcap` set.
- R8: `bl_sel` is sampled with the command: 0, 1, 2 and 3 select BL = 1, 2, 4 and 8. Column k of a burst (k = 0..BL-1) is base + ((start mod BL) + k) mod BL, where base = start - (start mod BL).
- R9: While no burst is running, a low clock enable suspends nothing: `frozen` stays low and commands are decoded on every edge.
- R10: A READ or WRITE on a non-suspended edge ends any burst in progress. On that same edge, the read output still delivers the current word of a running read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; sampled low while a burst is running, it suspends the following edge |
| cmd | input | 2 | Command: 0 no-op, 1 READ, 2 WRITE, 3 no-op |
| bank | input | BANK_W | Bank address for the command |
| col | input | COL_W | Start column for the command |
| bl_sel | input | 2 | Burst length select: 0=1, 1=2, 2=4, 3=8 |
| wdata | input | DATA_W | Write data |
| arr_rdata | input | DATA_W | Word returned by the storage array for arr_bank/arr_col |
| arr_bank | output | BANK_W | Bank of the current burst column |
| arr_col | output | COL_W | Current burst column |
| rdata | output | DATA_W | Registered read data |
| rvalid | output | 1 | Read data valid |
| wstrobe | output | 1 | One-cycle write capture strobe |
| wbank | output | BANK_W | Bank of the captured write |
| wcol | output | COL_W | Column of the captured write |
| wcap | output | DATA_W | Captured write data |
| frozen | output | 1 | The coming edge is suspended |

## Verification
The bench uses start columns in the middle of an aligned block, so a design that counted past the block edge instead of wrapping would return the wrong word. It drops the enable for one cycle and for several cycles during read and write bursts. A design that cut the one-edge lag, or used it twice, would freeze the wrong edge and lose or repeat a column. While suspended, the bench offers commands and fresh write data that must be dropped; a design that decoded them would restart the burst or strobe a write. It also holds the enable low while idle, where a design that suspended anyway would miss a command. It interrupts running bursts, where a design that let the old burst keep going would emit extra words.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } sbs_cmd_e;

    // burst length select to wrap mask (BL-1)
    function automatic logic [2:0] bl_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/sbs_col_next.sv
module sbs_col_next #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] cur,
    input  logic [2:0]       mask,
    output logic [COL_W-1:0] nxt
);
    logic [COL_W-1:0] wide_mask;
    logic [COL_W-1:0] inc;

    always_comb begin
        wide_mask = {{(COL_W-3){1'b0}}, mask};
        inc       = cur + 1'b1;
        nxt       = (cur & ~wide_mask) | (inc & wide_mask);
    end
endmodule

// File: rtl/sbs_cke_gate.sv
module sbs_cke_gate (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic busy,
    output logic frozen
);
    logic ien_d, ien_q;

    always_comb begin
        ien_d  = cke;
        frozen = busy && !ien_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ien_q <= 1'b1;
        else     ien_q <= ien_d;
    end
endmodule

// File: rtl/sdram_burst_susp.sv
module sdram_burst_susp #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [1:0]        bl_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [BANK_W-1:0] arr_bank,
    output logic [COL_W-1:0]  arr_col,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              wstrobe,
    output logic [BANK_W-1:0] wbank,
    output logic [COL_W-1:0]  wcol,
    output logic [DATA_W-1:0] wcap,
    output logic              frozen
);
    import sbs_pkg::*;

    typedef struct packed {
        logic              active;
        logic              is_rd;
        logic [BANK_W-1:0] bnk;
        logic [COL_W-1:0]  cur;
        logic [2:0]        cnt;
        logic [2:0]        mask;
        logic [DATA_W-1:0] rd;
        logic              rv;
        logic              ws;
        logic [BANK_W-1:0] wb;
        logic [COL_W-1:0]  wc;
        logic [DATA_W-1:0] wd;
    } st_t;

    st_t st_d, st_q;
    logic             busy;
    logic [2:0]       cmd_mask;
    logic [COL_W-1:0] start_nxt;
    logic [COL_W-1:0] cur_nxt;
    sbs_cmd_e         cmd_e;

    assign busy     = st_q.active;
    assign cmd_mask = bl_mask(bl_sel);
    assign cmd_e    = sbs_cmd_e'(cmd);

    sbs_cke_gate i_gate (
        .clk    (clk),
        .rst    (rst),
        .cke    (cke),
        .busy   (busy),
        .frozen (frozen)
    );

    sbs_col_next #(.COL_W(COL_W)) i_start_nxt (
        .cur  (col),
        .mask (cmd_mask),
        .nxt  (start_nxt)
    );

    sbs_col_next #(.COL_W(COL_W)) i_cur_nxt (
        .cur  (st_q.cur),
        .mask (st_q.mask),
        .nxt  (cur_nxt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ws = 1'b0;
        if (!frozen) begin
            // read path: deliver current column of a running read burst
            if (st_q.active && st_q.is_rd) begin
                st_d.rd = arr_rdata;
                st_d.rv = 1'b1;
            end else begin
                st_d.rv = 1'b0;
            end
            // write path: capture current column of a running write burst
            if (st_q.active && !st_q.is_rd) begin
                st_d.ws = 1'b1;
                st_d.wb = st_q.bnk;
                st_d.wc = st_q.cur;
                st_d.wd = wdata;
            end
            // advance the burst
            if (st_q.active) begin
                st_d.cur = cur_nxt;
                st_d.cnt = st_q.cnt + 3'd1;
                if (st_q.cnt == st_q.mask) st_d.active = 1'b0;
            end
            // new command ends any running burst
            case (cmd_e)
                CMD_READ: begin
                    st_d.active = 1'b1;
                    st_d.is_rd  = 1'b1;
                    st_d.bnk    = bank;
                    st_d.cur    = col;
                    st_d.cnt    = 3'd0;
                    st_d.mask   = cmd_mask;
                end
                CMD_WRITE: begin
                    st_d.ws     = 1'b1;
                    st_d.wb     = bank;
                    st_d.wc     = col;
                    st_d.wd     = wdata;
                    st_d.active = (cmd_mask != 3'd0);
                    st_d.is_rd  = 1'b0;
                    st_d.bnk    = bank;
                    st_d.cur    = start_nxt;
                    st_d.cnt    = 3'd1;
                    st_d.mask   = cmd_mask;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign arr_bank = st_q.bnk;
    assign arr_col  = st_q.cur;
    assign rdata    = st_q.rd;
    assign rvalid   = st_q.rv;
    assign wstrobe  = st_q.ws;
    assign wbank    = st_q.wb;
    assign wcol     = st_q.wc;
    assign wcap     = st_q.wd;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
    parameter int COL_W  = 9,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              busy,
    input logic              frozen,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic              wstrobe,
    input logic [COL_W-1:0]  arr_col
);
    // R2
    susp_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cke) && !$past(rst) && busy) |-> frozen);

    // R3
    susp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        frozen |=> ($stable(rdata) && $stable(rvalid)));

    // R4
    susp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        frozen |=> (!wstrobe && $stable(arr_col)));

    // R5
    resume_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cke) && !$past(rst)) |-> !frozen);

    // R6
    rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> $past(busy));

    // R9
    idle_nofreeze_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !frozen);
endmodule

bind sdram_burst_susp sbs_chk #(.COL_W(COL_W), .DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .cke     (cke),
    .busy    (busy),
    .frozen  (frozen),
    .rvalid  (rvalid),
    .rdata   (rdata),
    .wstrobe (wstrobe),
    .arr_col (arr_col)
);

// File: tb/test_sdram_burst_susp.sv
module test_sdram_burst_susp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic [1:0]  cmd = 2'd0;
    logic [1:0]  bank = 2'd0;
    logic [8:0]  col = 9'd0;
    logic [1:0]  bl_sel = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] arr_rdata;
    logic [1:0]  arr_bank;
    logic [8:0]  arr_col;
    logic [15:0] rdata;
    logic        rvalid;
    logic        wstrobe;
    logic [1:0]  wbank;
    logic [8:0]  wcol;
    logic [15:0] wcap;
    logic        frozen;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // behavioural reference state
    int   q_rd[$];
    int   q_wr[$];
    bit   m_ien = 1'b1;
    bit   m_susp = 1'b0;
    int   rd_bank = 0, wr_bank = 0;
    logic [15:0] e_rd = '0;
    bit   e_rv = 0, e_ws = 0;
    int   e_wc = 0, e_wb = 0;
    logic [15:0] e_wd = '0;

    always #10 clk = ~clk;

    function automatic logic [15:0] arrf(input logic [1:0] b, input logic [8:0] c);
        return {b, c, 5'b10101} ^ 16'h5A3C;
    endfunction

    assign arr_rdata = arrf(arr_bank, arr_col);

    sdram_burst_susp i_sdram_burst_susp (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
        .bl_sel(bl_sel), .wdata(wdata), .arr_rdata(arr_rdata),
        .arr_bank(arr_bank), .arr_col(arr_col), .rdata(rdata), .rvalid(rvalid),
        .wstrobe(wstrobe), .wbank(wbank), .wcol(wcol), .wcap(wcap), .frozen(frozen)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL [%s] %s: actual %0h expected %0h", phase, tag, act, exp);
        end
    endtask

    function automatic int burst_col(input int start, input int bl, input int k);
        int base = start - (start % bl);
        return base + ((start % bl) + k) % bl;
    endfunction

    task automatic step(input int cm, input int b, input int c, input int bs,
                        input bit ck);
        int bl = 1 << bs;
        logic [15:0] wd = 16'($urandom);
        bit busy;
        cmd = 2'(cm); bank = 2'(b); col = 9'(c); bl_sel = 2'(bs); wdata = wd; cke = ck;
        @(posedge clk);
        busy   = (q_rd.size() > 0) || (q_wr.size() > 0);
        m_susp = !m_ien && busy;
        m_ien  = ck;
        if (m_susp) begin
            e_ws = 0;
        end else begin
            if (q_rd.size() > 0) begin
                e_rv = 1;
                e_rd = arrf(2'(rd_bank), 9'(q_rd.pop_front()));
            end else e_rv = 0;
            e_ws = 0;
            if (q_wr.size() > 0) begin
                e_ws = 1; e_wc = q_wr.pop_front(); e_wb = wr_bank; e_wd = wd;
            end
            if (cm == 1) begin
                q_rd.delete(); q_wr.delete(); rd_bank = b;
                for (int k = 0; k < bl; k++) q_rd.push_back(burst_col(c, bl, k));
            end else if (cm == 2) begin
                q_rd.delete(); q_wr.delete(); wr_bank = b;
                e_ws = 1; e_wc = c; e_wb = b; e_wd = wd;
                for (int k = 1; k < bl; k++) q_wr.push_back(burst_col(c, bl, k));
            end
        end
        @(negedge clk);
        chk(rvalid == e_rv, m_susp ? "R3 rvalid hold" : "R6 rvalid", rvalid, e_rv);
        chk(rdata == e_rd, m_susp ? "R3 rdata hold" : "R6 rdata", rdata, e_rd);
        chk(wstrobe == e_ws, m_susp ? "R4 wstrobe" : "R7 wstrobe", wstrobe, e_ws);
        if (e_ws) begin
            chk(wcol == 9'(e_wc), "R7 wcol", wcol, e_wc);
            chk(wbank == 2'(e_wb), "R7 wbank", wbank, e_wb);
            chk(wcap == e_wd, "R7 wcap", wcap, e_wd);
        end
        busy = (q_rd.size() > 0) || (q_wr.size() > 0);
        chk(frozen == (!m_ien && busy), "R2 frozen", frozen, !m_ien && busy);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1'b1);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL [watchdog] R1: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(rvalid == 1'b0, "R1 rvalid", rvalid, 0);
        chk(wstrobe == 1'b0, "R1 wstrobe", wstrobe, 0);
        chk(frozen == 1'b0, "R1 frozen", frozen, 0);
        chk(rdata == 16'd0, "R1 rdata", rdata, 0);

        phase = "R6";
        step(1, 2, 5, 2, 1'b1);
        nops(6);

        phase = "R8";
        step(1, 1, 13, 3, 1'b1); nops(10);
        step(1, 3, 7, 0, 1'b1);  nops(3);
        step(2, 0, 3, 1, 1'b1);  nops(3);
        step(2, 2, 22, 3, 1'b1); nops(9);

        phase = "R3";
        step(1, 0, 2, 2, 1'b1);
        step(0, 0, 0, 0, 1'b0);
        step(2, 1, 40, 2, 1'b0);
        step(1, 1, 41, 2, 1'b1);
        nops(6);

        phase = "R4";
        step(2, 3, 30, 3, 1'b1);
        step(0, 0, 0, 0, 1'b1);
        step(1, 0, 9, 1, 1'b0);
        step(2, 0, 9, 1, 1'b0);
        step(2, 0, 9, 1, 1'b1);
        step(0, 0, 0, 0, 1'b0);
        nops(10);

        phase = "R5";
        step(1, 2, 100, 3, 1'b0);
        step(0, 0, 0, 0, 1'b1);
        step(0, 0, 0, 0, 1'b0);
        step(0, 0, 0, 0, 1'b1);
        nops(10);

        phase = "R9";
        step(0, 0, 0, 0, 1'b0);
        step(0, 0, 0, 0, 1'b0);
        step(1, 1, 50, 1, 1'b0);
        step(0, 0, 0, 0, 1'b1);
        nops(3);
        step(0, 0, 0, 0, 1'b0);
        step(2, 2, 60, 2, 1'b0);
        nops(5);

        phase = "R10";
        step(1, 0, 16, 3, 1'b1);
        nops(3);
        step(2, 1, 70, 2, 1'b1);
        step(0, 0, 0, 0, 1'b1);
        step(1, 2, 75, 2, 1'b1);
        nops(6);

        phase = "R7";
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 9);
            int cm = (r < 2) ? 1 : (r < 4) ? 2 : 0;
            step(cm, $urandom_range(0, 3), $urandom_range(0, 511),
                 $urandom_range(0, 3), ($urandom_range(0, 9) < 7));
        end
        nops(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule